// File: doc/BRIEF.md
# One-Time-Programmable Fuse Read Controller

This block is a register-mapped front end for an 8-Kbit one-time-programmable fuse array that is split into two 4-Kbit halves. Software first loads a timing register with an address-setup count and a strobe-width count. It then writes a command register with a half-select bit, a 9-bit byte address within that half, a byte count and a read enable. The controller drives the fuse macro's half-select, address and read strobe itself, one timed access per byte. It moves the byte address forward after each access and lands each byte in an eight-word buffer that software reads back.

When the last byte of the burst has been captured, a sticky completion flag rises. With the interrupt enable set, the interrupt output follows that flag. The fuse macro is modelled as a synchronous byte array that latches the addressed byte while the strobe is high. The programming fields of the registers are kept for readback only and never move the fuse interface.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the command, timing and status registers and all eight data words read as zero. A register read returns its value on `bus_rdata` one clock after the request, and offsets with no register read zero.
- R2: The timing register keeps interrupt enable in bit 31, read setup in bits 23:20, read strobe in bits 19:16, write setup in bits 15:12 and write strobe in bits 11:0. Bits 30:24 always read zero.
- R3: A command write with bit 0 set while idle starts a read and clears the done flag (status bit 0) in the same clock. Bit 0 of the command register reads 1 for the whole read and returns to 0 when the read finishes. All other command fields keep the written value.
- R4: For each byte the address is valid for setup+1 cycles before the strobe rises. The strobe stays high for strobe+2 cycles, and each byte access lasts setup+strobe+5 cycles from address valid to data capture.
- R5: The command register holds the half-select in bit 30, the start address in bits 29:21 and the byte count minus one in bits 20:16. A read fetches count bytes from fuse index {half, address}, and the address advances by one per byte modulo 512 within the selected half.
- R6: Byte i of a burst is placed in data word i/4 (offset 0x0C + 4*word) at bits 8*(i mod 4) upward. Buffer bytes beyond the burst length keep their previous contents.
- R7: The done flag rises exactly N*(setup+strobe+5) clocks after the starting command write, for N bytes. It stays set until the next read starts. `irq` equals the done flag ANDed with the interrupt enable.
- R8: A command-register write during a read is ignored completely: neither the running read nor the command register readback changes.
- R9: The program-enable bit 15 and write-enable bit 1 of the command register are stored and read back, but they cause no strobe. Write-done (status bit 1) is always zero, and writes to the status and data offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the request |
| irq | output | 1 | Completion interrupt |
| fuse_cs | output | 1 | Fuse half select, 1 = upper half |
| fuse_addr | output | 9 | Byte address within the selected half |
| fuse_strobe | output | 1 | Fuse read strobe |
| fuse_rdata | input | 8 | Byte latched by the fuse array during the strobe |

## Verification
The hardest case to reach is a command write that lands while a read is still running. A short burst leaves only a handful of cycles for it, and software normally waits for done. The bench sets both timing counts to their maximum and requests eight bytes, which stretches the read to 280 clocks. It then injects a second command with a different address during that window. The buffer and the command readback must both show the first command. The strobe timing is measured cycle by cycle against an idle bus, so that no register polling disturbs the count from the command edge to the strobe edges and the done edge.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int BUS_AW  = 8;
    localparam int ADDR_W  = 9;
    localparam int LEN_W   = 5;
    localparam int TIM_W   = 4;
    localparam int NWORDS  = 8;
    localparam int NBYTES  = NWORDS * 4;
    localparam int BIDX_W  = $clog2(NBYTES);
    localparam int WIDX_W  = BIDX_W - 2;
    localparam int CNT_W   = TIM_W + 2;

    localparam logic [BUS_AW-1:0] OFF_CMD  = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_TIM  = 8'h04;
    localparam logic [BUS_AW-1:0] OFF_STAT = 8'h08;
    localparam int                OFF_BUF  = 12;

    typedef struct packed {
        logic              half;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  cnt_m1;
        logic              prog;
        logic              wen;
        logic              ren;
    } cmd_t;

    typedef struct packed {
        logic             irq_en;
        logic [TIM_W-1:0] rd_setup;
        logic [TIM_W-1:0] rd_width;
        logic [3:0]       wr_setup;
        logic [11:0]      wr_width;
    } tim_t;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    function automatic logic [31:0] cmd_to_word(cmd_t c);
        return {1'b0, c.half, c.addr, c.cnt_m1, c.prog, 13'b0, c.wen, c.ren};
    endfunction

    function automatic cmd_t word_to_cmd(logic [31:0] w);
        cmd_t c;
        c.half   = w[30];
        c.addr   = w[29:21];
        c.cnt_m1 = w[20:16];
        c.prog   = w[15];
        c.wen    = w[1];
        c.ren    = w[0];
        return c;
    endfunction

    function automatic logic [31:0] tim_to_word(tim_t t);
        return {t.irq_en, 7'b0, t.rd_setup, t.rd_width, t.wr_setup, t.wr_width};
    endfunction

    function automatic tim_t word_to_tim(logic [31:0] w);
        tim_t t;
        t.irq_en   = w[31];
        t.rd_setup = w[23:20];
        t.rd_width = w[19:16];
        t.wr_setup = w[15:12];
        t.wr_width = w[11:0];
        return t;
    endfunction

    // Last cycle index of one byte access: setup+1 + width+2 + 2 hold - 1
    function automatic logic [CNT_W-1:0] access_last(logic [TIM_W-1:0] su,
                                                     logic [TIM_W-1:0] wd);
        return CNT_W'(su) + CNT_W'(wd) + CNT_W'(4);
    endfunction

endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
    import fuse_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_en,
    input  logic                        bus_we,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic                        seq_busy,
    input  logic                        seq_done,
    input  logic [NWORDS-1:0][31:0]     buf_words,
    output cmd_t                        cmd_q,
    output tim_t                        tim_q,
    output logic                        rd_done,
    output logic                        start
);

    logic        wr_cmd;
    logic        wr_tim;
    logic [31:0] rd_mux;

    assign wr_cmd = bus_en && bus_we && (bus_addr == OFF_CMD) && !seq_busy;
    assign wr_tim = bus_en && bus_we && (bus_addr == OFF_TIM);
    assign start  = wr_cmd && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            tim_q     <= '0;
            rd_done   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (wr_cmd) begin
                cmd_q <= word_to_cmd(bus_wdata);
            end else if (seq_done) begin
                cmd_q.ren <= 1'b0;
            end
            if (wr_tim) begin
                tim_q <= word_to_tim(bus_wdata);
            end
            if (start) begin
                rd_done <= 1'b0;
            end else if (seq_done) begin
                rd_done <= 1'b1;
            end
            if (bus_en && !bus_we) begin
                bus_rdata <= rd_mux;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFF_CMD) begin
            rd_mux = cmd_to_word(cmd_q);
        end else if (bus_addr == OFF_TIM) begin
            rd_mux = tim_to_word(tim_q);
        end else if (bus_addr == OFF_STAT) begin
            rd_mux = {30'b0, 1'b0, rd_done};
        end
        for (int n = 0; n < NWORDS; n++) begin
            if (bus_addr == BUS_AW'(OFF_BUF + 4 * n)) begin
                rd_mux = buf_words[n];
            end
        end
    end

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cmd_half,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [LEN_W-1:0]   cmd_cnt_m1,
    input  logic [TIM_W-1:0]   tim_setup,
    input  logic [TIM_W-1:0]   tim_width,
    output logic               busy,
    output logic               done,
    output logic               cap,
    output logic [BIDX_W-1:0]  cap_idx,
    output logic               fuse_cs,
    output logic [ADDR_W-1:0]  fuse_addr,
    output logic               fuse_strobe
);

    seq_state_e        state;
    logic [CNT_W-1:0]  phase;
    logic [BIDX_W-1:0] bidx;
    logic [BIDX_W-1:0] blast;
    logic [ADDR_W-1:0] addr_q;
    logic              half_q;
    logic [TIM_W-1:0]  su_q;
    logic [TIM_W-1:0]  wd_q;
    logic [CNT_W-1:0]  strobe_lo;
    logic [CNT_W-1:0]  strobe_hi;
    logic [CNT_W-1:0]  phase_last;

    assign strobe_lo  = CNT_W'(su_q) + CNT_W'(1);
    assign strobe_hi  = CNT_W'(su_q) + CNT_W'(wd_q) + CNT_W'(2);
    assign phase_last = access_last(su_q, wd_q);

    assign busy        = (state == SEQ_RUN);
    assign cap         = busy && (phase == phase_last);
    assign done        = cap && (bidx == blast);
    assign cap_idx     = bidx;
    assign fuse_cs     = half_q;
    assign fuse_addr   = addr_q;
    assign fuse_strobe = busy && (phase >= strobe_lo) && (phase <= strobe_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            phase  <= '0;
            bidx   <= '0;
            blast  <= '0;
            addr_q <= '0;
            half_q <= 1'b0;
            su_q   <= '0;
            wd_q   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state  <= SEQ_RUN;
                        phase  <= '0;
                        bidx   <= '0;
                        blast  <= BIDX_W'(cmd_cnt_m1);
                        addr_q <= cmd_addr;
                        half_q <= cmd_half;
                        su_q   <= tim_setup;
                        wd_q   <= tim_width;
                    end
                end
                SEQ_RUN: begin
                    if (cap) begin
                        if (bidx == blast) begin
                            state <= SEQ_IDLE;
                        end else begin
                            bidx   <= bidx + BIDX_W'(1);
                            addr_q <= addr_q + ADDR_W'(1);
                            phase  <= '0;
                        end
                    end else begin
                        phase <= phase + CNT_W'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fuse_buf.sv
module fuse_buf
    import fuse_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [BIDX_W-1:0]       wr_idx,
    input  logic [7:0]              wr_byte,
    output logic [NWORDS-1:0][31:0] words
);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_lane
            logic hit;
            assign hit = wr_en && (wr_idx[BIDX_W-1:2] == WIDX_W'(w))
                               && (wr_idx[1:0] == 2'(b));
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[w][8*b +: 8] <= 8'h00;
                end else if (hit) begin
                    words[w][8*b +: 8] <= wr_byte;
                end
            end
        end
    end

endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              fuse_cs,
    output logic [ADDR_W-1:0] fuse_addr,
    output logic              fuse_strobe,
    input  logic [7:0]        fuse_rdata
);

    cmd_t                    cmd_q;
    tim_t                    tim_q;
    logic                    rd_done;
    logic                    start;
    logic                    seq_busy;
    logic                    seq_done;
    logic                    cap;
    logic [BIDX_W-1:0]       cap_idx;
    logic [NWORDS-1:0][31:0] buf_words;

    fuse_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .seq_busy  (seq_busy),
        .seq_done  (seq_done),
        .buf_words (buf_words),
        .cmd_q     (cmd_q),
        .tim_q     (tim_q),
        .rd_done   (rd_done),
        .start     (start)
    );

    fuse_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cmd_half    (bus_wdata[30]),
        .cmd_addr    (bus_wdata[29:21]),
        .cmd_cnt_m1  (bus_wdata[20:16]),
        .tim_setup   (tim_q.rd_setup),
        .tim_width   (tim_q.rd_width),
        .busy        (seq_busy),
        .done        (seq_done),
        .cap         (cap),
        .cap_idx     (cap_idx),
        .fuse_cs     (fuse_cs),
        .fuse_addr   (fuse_addr),
        .fuse_strobe (fuse_strobe)
    );

    fuse_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cap),
        .wr_idx  (cap_idx),
        .wr_byte (fuse_rdata),
        .words   (buf_words)
    );

    assign irq = tim_q.irq_en && rd_done;

endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk
    import fuse_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              fuse_cs,
    input logic [ADDR_W-1:0] fuse_addr,
    input logic              fuse_strobe,
    input logic              seq_busy,
    input logic              seq_done,
    input logic              cmd_ren
);

    a_r4_strobe_only_in_read: assert property (@(posedge clk) disable iff (rst)
        fuse_strobe |-> seq_busy);

    a_r4_addr_held_in_strobe: assert property (@(posedge clk) disable iff (rst)
        (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

    a_r5_half_held_in_read: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && $past(seq_busy)) |-> $stable(fuse_cs));

    a_r3_enable_while_busy: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> cmd_ren);

    a_r3_start_clears_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_busy) |-> !irq);

    a_r7_done_ends_read: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> (!seq_busy && !cmd_ren));

endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .fuse_cs     (fuse_cs),
    .fuse_addr   (fuse_addr),
    .fuse_strobe (fuse_strobe),
    .seq_busy    (seq_busy),
    .seq_done    (seq_done),
    .cmd_ren     (cmd_q.ren)
);

// File: tb/tb_fuse_rd_ctrl.sv
module tb_fuse_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        fuse_cs;
    logic [8:0]  fuse_addr;
    logic        fuse_strobe;
    logic [7:0]  fuse_rdata = '0;

    logic [7:0]  fmem [0:1023];
    logic [31:0] exp_words [0:7];
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    fuse_rd_ctrl dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .fuse_cs(fuse_cs), .fuse_addr(fuse_addr),
        .fuse_strobe(fuse_strobe), .fuse_rdata(fuse_rdata)
    );

    // Fuse array model: latches the addressed byte while the strobe is high
    always @(posedge clk) begin
        if (fuse_strobe) fuse_rdata <= fmem[{fuse_cs, fuse_addr}];
    end

    function automatic logic [31:0] mk_cmd(logic half, logic [8:0] addr,
                                           logic [4:0] cm1, logic prog,
                                           logic wen, logic ren);
        return {1'b0, half, addr, cm1, prog, 13'b0, wen, ren};
    endfunction

    function automatic logic [31:0] mk_tim(logic ie, logic [3:0] su, logic [3:0] wd);
        return {ie, 7'b0, su, wd, 4'h0, 12'h000};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(8'h08, s);
            if (s[0]) return;
        end
    endtask

    task automatic expect_burst(logic half, logic [8:0] addr, logic [4:0] cm1);
        for (int i = 0; i <= int'(cm1); i++) begin
            logic [8:0] a;
            a = addr + 9'(i);
            exp_words[i / 4][8 * (i % 4) +: 8] = fmem[{half, a}];
        end
    endtask

    task automatic check_buffer(string req);
        logic [31:0] d;
        for (int n = 0; n < 8; n++) begin
            bus_read(8'(12 + 4 * n), d);
            chk(req, d, exp_words[n]);
        end
    endtask

    // R4 R7 R5 R6: timed burst measured on an idle bus
    task automatic run_timed(logic half, logic [8:0] addr, logic [4:0] cm1,
                             logic [3:0] su, logic [3:0] wd);
        int idx = 0;
        int first = -1;
        int swide = 0;
        int nbytes = int'(cm1) + 1;
        int per = int'(su) + int'(wd) + 5;
        bus_write(8'h04, mk_tim(1'b1, su, wd));
        bus_write(8'h00, mk_cmd(half, addr, cm1, 1'b0, 1'b0, 1'b1));
        while (!irq && idx < 5000) begin
            if (fuse_strobe && first < 0) first = idx;
            if (fuse_strobe) swide++;
            @(negedge clk);
            idx++;
        end
        chk("R4 setup cycles", 32'(first), 32'(int'(su) + 1));
        chk("R4 strobe cycles", 32'(swide), 32'(nbytes * (int'(wd) + 2)));
        chk("R7 done latency", 32'(idx), 32'(nbytes * per));
        expect_burst(half, addr, cm1);
        check_buffer("R5 R6 burst data");
    endtask

    task automatic test_reset();
        logic [31:0] d;
        bus_read(8'h00, d); chk("R1 cmd reset", d, 32'h0);
        bus_read(8'h04, d); chk("R1 tim reset", d, 32'h0);
        bus_read(8'h08, d); chk("R1 status reset", d, 32'h0);
        bus_read(8'h40, d); chk("R1 unmapped", d, 32'h0);
        check_buffer("R1 buffer reset");
    endtask

    task automatic test_tim_fields();
        logic [31:0] d;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, d); chk("R2 tim all ones", d, 32'h80FF_FFFF);
        bus_write(8'h04, 32'h7A5C_3123);
        bus_read(8'h04, d); chk("R2 tim pattern", d, 32'h005C_3123);
    endtask

    task automatic test_busy_cmd();
        logic [31:0] d;
        logic [31:0] c1;
        c1 = mk_cmd(1'b0, 9'h0A0, 5'd7, 1'b0, 1'b0, 1'b1);
        bus_write(8'h04, mk_tim(1'b0, 4'hF, 4'hF));
        bus_write(8'h00, c1);
        bus_read(8'h00, d); chk("R3 enable reads 1 while busy", d, c1);
        bus_read(8'h08, d); chk("R3 done cleared at start", d, 32'h0);
        bus_write(8'h00, mk_cmd(1'b1, 9'h033, 5'd31, 1'b0, 1'b0, 1'b1));
        wait_done();
        bus_read(8'h00, d); chk("R8 R3 cmd after busy write", d, c1 & ~32'h1);
        expect_burst(1'b0, 9'h0A0, 5'd7);
        check_buffer("R8 data of first command");
    endtask

    task automatic test_sticky();
        logic [31:0] d;
        bus_write(8'h04, mk_tim(1'b0, 4'h1, 4'h1));
        bus_write(8'h00, mk_cmd(1'b1, 9'h000, 5'd0, 1'b0, 1'b0, 1'b1));
        wait_done();
        repeat (20) @(negedge clk);
        chk("R7 irq masked", 32'(irq), 32'h0);
        bus_read(8'h08, d); chk("R7 done sticky", d, 32'h1);
        bus_write(8'h04, mk_tim(1'b1, 4'h1, 4'h1));
        @(negedge clk);
        chk("R7 irq follows done", 32'(irq), 32'h1);
        expect_burst(1'b1, 9'h000, 5'd0);
        check_buffer("R6 single byte keeps rest");
    endtask

    task automatic test_prog_bits();
        logic [31:0] d;
        logic [31:0] c;
        int seen = 0;
        c = mk_cmd(1'b1, 9'h155, 5'd4, 1'b1, 1'b1, 1'b0);
        bus_write(8'h00, c);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (fuse_strobe) seen++;
        end
        chk("R9 no strobe from prog bits", 32'(seen), 32'h0);
        bus_read(8'h00, d); chk("R9 prog bits stored", d, c);
        bus_read(8'h08, d); chk("R9 write-done zero", d, 32'h1);
        bus_write(8'h08, 32'h0000_0000);
        bus_write(8'h0C, 32'hDEAD_BEEF);
        bus_write(8'h28, 32'h1234_5678);
        bus_read(8'h08, d); chk("R9 status write ignored", d, 32'h1);
        check_buffer("R9 data writes ignored");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) fmem[i] = 8'((i * 29 + 7) ^ (i >> 2));
        for (int n = 0; n < 8; n++) exp_words[n] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_tim_fields();
        run_timed(1'b0, 9'h010, 5'd3, 4'd2, 4'd3);
        run_timed(1'b1, 9'h1F0, 5'd31, 4'd0, 4'd0);
        run_timed(1'b0, 9'h1FE, 5'd2, 4'd5, 4'd1);
        test_busy_cmd();
        test_sticky();
        test_prog_bits();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule